// File: doc/BRIEF.md
# AC-Link Playback Frame Serializer

This block assembles the controller-to-codec frame of an AC-Link audio interface and shifts it out one bit per codec bit clock. Five playback sources (main stereo, modem line output, center-or-headset, surround stereo and low-frequency effects) each offer 16-bit samples through a valid/ready pair. A register-command source offers an address word and a data word. Once per frame, on the last bit time, the block takes whatever is valid at that moment and builds the next frame from it. A source that has nothing ready is skipped. Its slot goes out as zeros with the tag cleared, and the frame is never held back.

The first 16 bits of each frame form a tag field: a frame-valid flag followed by one tag bit per data slot. Twelve 20-bit slots follow. SYNC is high while the tag field is on the wire. A run-time select input routes the center/headset source either to slot 6 or to slot 11. The bit clock comes from the codec. The block drives SYNC and serial data from registers clocked on its rising edge.

Top module: `aclink_out_framer`

## Requirements
- R1: A frame is 256 bit times long and is sent most significant bit first. The 16-bit tag field comes first. Data slot s (1 to 12) begins at bit time 16 + 20*(s-1).
- R2: `sync` is high for the first 16 bit times of every frame and low for the remaining 240.
- R3: `ch_ready` (all bits) and `cmd_ready` are high for exactly one bit clock per frame, during its last bit time. Items presented with valid in that cycle fill the next frame. Inputs in any other cycle have no effect.
- R4: In the tag field, the first bit sent is the frame-valid flag, equal to the OR of all slot tags. The tag for slot s is the (s+1)-th bit sent. The last three bits sent are zero.
- R5: Main stereo is channel lane 0. Bits [31:16] of the lane go in slot 3 and bits [15:0] go in slot 4.
- R6: Modem line output (lane 1, bits [15:0]) goes in slot 5. Low-frequency effects (lane 4, bits [15:0]) goes in slot 9.
- R7: Surround is lane 3. Bits [31:16] go in slot 7 and bits [15:0] go in slot 8.
- R8: Center/headset is lane 2, bits [15:0]. With `hs_sel`=0 at the capture edge it goes in slot 6 and slot 11 is zero and untagged. With `hs_sel`=1 it goes in slot 11 and slot 6 is zero and untagged.
- R9: A 16-bit sample fills the upper 16 bits of its 20-bit slot. The low 4 bits are zero.
- R10: A source that is not valid at the capture edge yields an all-zero, untagged slot. Slots 10 and 12 are always zero and untagged.
- R11: When `cmd_valid` is high at the capture edge, slot 1 carries `cmd_addr` and slot 2 carries `cmd_data` (20 bits each), both tagged. Otherwise both slots are zero and untagged.
- R12: During reset and in the first frame after reset, `sync` is high for the tag field and every bit of the frame is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_sel | input | 1 | Center/headset routing: 0 selects slot 6, 1 selects slot 11 |
| ch_valid | input | 5 | Sample valid per lane (0 main, 1 modem, 2 center/headset, 3 surround, 4 LFE) |
| ch_data | input | 160 | 32 bits per lane at [32*i +: 32]; stereo uses both halves, mono uses bits [15:0] |
| ch_ready | output | 5 | Sample accepted per lane, high on the last bit time of each frame |
| cmd_valid | input | 1 | Register command pending |
| cmd_addr | input | 20 | Command address slot word |
| cmd_data | input | 20 | Command data slot word |
| cmd_ready | output | 1 | Command accepted, same timing as `ch_ready` |
| sync | output | 1 | Frame sync, high during the tag field |
| sdata | output | 1 | Serial frame data, MSB first |

## Verification
A wrong bit counter appears on the next frame boundary as a SYNC pulse that is not 16 bits long, or a frame period other than 256. A wrong routing or tag decision appears one full frame after the capture edge, because the captured word only reaches the wire in the frame that follows. The scoreboard therefore compares each whole frame, slot by slot, against an expectation queued at capture time. The bench changes the data and `hs_sel` straight after each capture edge, so any late sampling of those inputs corrupts the frame that is already shifting out.

// File: rtl/aclink_out_pkg.sv
package aclink_out_pkg;

   localparam logic [2:0] LANE_MAIN   = 3'd0;
   localparam logic [2:0] LANE_MODEM  = 3'd1;
   localparam logic [2:0] LANE_CTRHS  = 3'd2;
   localparam logic [2:0] LANE_SURR   = 3'd3;
   localparam logic [2:0] LANE_LFE    = 3'd4;

   // Where a data slot gets its sample: lane index and which half of the lane
   typedef struct packed {
      logic       used;
      logic [2:0] lane;
      logic       upper;
   } slot_src_t;

   function automatic slot_src_t slot_source(input int unsigned slot, input logic hs);
      slot_src_t r;
      r = '0;
      case (slot)
         3:  r = '{used: 1'b1, lane: LANE_MAIN,  upper: 1'b1};
         4:  r = '{used: 1'b1, lane: LANE_MAIN,  upper: 1'b0};
         5:  r = '{used: 1'b1, lane: LANE_MODEM, upper: 1'b0};
         6:  r = '{used: !hs,  lane: LANE_CTRHS, upper: 1'b0};
         7:  r = '{used: 1'b1, lane: LANE_SURR,  upper: 1'b1};
         8:  r = '{used: 1'b1, lane: LANE_SURR,  upper: 1'b0};
         9:  r = '{used: 1'b1, lane: LANE_LFE,   upper: 1'b0};
         11: r = '{used: hs,   lane: LANE_CTRHS, upper: 1'b0};
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/aclink_slot_mapper.sv
module aclink_slot_mapper
   import aclink_out_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int NUM_CH    = 5
) (
   input  logic                             hs_sel,
   input  logic [NUM_CH-1:0]                ch_valid,
   input  logic [NUM_CH*2*SAMPLE_W-1:0]     ch_data,
   input  logic                             cmd_valid,
   input  logic [SLOT_W-1:0]                cmd_addr,
   input  logic [SLOT_W-1:0]                cmd_data,
   output logic [NUM_SLOTS-1:0]             slot_tag,
   output logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_word
);

   localparam int LANE_W = 2 * SAMPLE_W;
   localparam int PAD_W  = SLOT_W - SAMPLE_W;

   logic [LANE_W-1:0] lane_a [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      assign lane_a[c] = ch_data[c*LANE_W +: LANE_W];
   end

   for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
      if (s == 1) begin : g_cmd_addr
         assign slot_tag[0]  = cmd_valid;
         assign slot_word[0] = cmd_valid ? cmd_addr : '0;
      end else if (s == 2) begin : g_cmd_data
         assign slot_tag[1]  = cmd_valid;
         assign slot_word[1] = cmd_valid ? cmd_data : '0;
      end else begin : g_sample
         slot_src_t         src;
         logic [LANE_W-1:0] lane;
         logic [SAMPLE_W-1:0] sample;
         always_comb begin
            src    = slot_source(s, hs_sel);
            lane   = lane_a[src.lane];
            sample = src.upper ? lane[LANE_W-1:SAMPLE_W] : lane[SAMPLE_W-1:0];
            if (src.used && ch_valid[src.lane]) begin
               slot_tag[s-1]  = 1'b1;
               slot_word[s-1] = {sample, {PAD_W{1'b0}}};
            end else begin
               slot_tag[s-1]  = 1'b0;
               slot_word[s-1] = '0;
            end
         end
      end
   end

endmodule

// File: rtl/aclink_frame_packer.sv
module aclink_frame_packer #(
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int TAG_W     = 16,
   localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W
) (
   input  logic [NUM_SLOTS-1:0]             slot_tag,
   input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_word,
   output logic [FRAME_BITS-1:0]            frame
);

   logic [TAG_W-1:0] tag_word;

   always_comb begin
      tag_word            = '0;
      tag_word[TAG_W-1]   = |slot_tag;
      for (int s = 1; s <= NUM_SLOTS; s++) begin
         tag_word[TAG_W-1-s] = slot_tag[s-1];
      end
   end

   assign frame[FRAME_BITS-1 -: TAG_W] = tag_word;

   for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_place
      assign frame[(NUM_SLOTS-s)*SLOT_W +: SLOT_W] = slot_word[s-1];
   end

endmodule

// File: rtl/aclink_frame_shifter.sv
module aclink_frame_shifter #(
   parameter int FRAME_BITS = 256,
   parameter int TAG_W      = 16,
   localparam int CNT_W     = $clog2(FRAME_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FRAME_BITS-1:0] frame_in,
   output logic                  load_strobe,
   output logic                  sync,
   output logic                  sdata
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(TAG_W);

   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] shreg;

   assign load_strobe = (bit_cnt == LAST_BIT);
   assign sync        = (bit_cnt < SYNC_END);
   assign sdata       = shreg[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (load_strobe) begin
         bit_cnt <= '0;
         shreg   <= frame_in;
      end else begin
         bit_cnt <= bit_cnt + 1'b1;
         shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
      end
   end

   // R2
   sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_strobe |=> $rose(sync));

   // R1
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_strobe |=> (sdata == $past(frame_in[FRAME_BITS-1])));

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_strobe |=> !load_strobe);

endmodule

// File: rtl/aclink_out_framer.sv
module aclink_out_framer #(
   parameter int SAMPLE_W  = 16,
   parameter int SLOT_W    = 20,
   parameter int NUM_SLOTS = 12,
   parameter int TAG_W     = 16,
   parameter int NUM_CH    = 5,
   localparam int LANE_W     = 2 * SAMPLE_W,
   localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W
) (
   input  logic                       bit_clk,
   input  logic                       rst_n,
   input  logic                       hs_sel,
   input  logic [NUM_CH-1:0]          ch_valid,
   input  logic [NUM_CH*LANE_W-1:0]   ch_data,
   output logic [NUM_CH-1:0]          ch_ready,
   input  logic                       cmd_valid,
   input  logic [SLOT_W-1:0]          cmd_addr,
   input  logic [SLOT_W-1:0]          cmd_data,
   output logic                       cmd_ready,
   output logic                       sync,
   output logic                       sdata
);

   if (SAMPLE_W >= SLOT_W) begin : g_bad_width
      $error("SAMPLE_W must be narrower than SLOT_W");
   end
   if (TAG_W < NUM_SLOTS + 1) begin : g_bad_tag
      $error("TAG_W too small for frame flag plus slot tags");
   end
   if (NUM_CH != 5 || NUM_SLOTS < 11) begin : g_bad_map
      $error("slot map needs five lanes and at least eleven slots");
   end

   logic [NUM_SLOTS-1:0]             slot_tag;
   logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_word;
   logic [FRAME_BITS-1:0]            frame;
   logic                             load_strobe;

   aclink_slot_mapper #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W),
      .NUM_SLOTS(NUM_SLOTS),
      .NUM_CH   (NUM_CH)
   ) u_mapper (
      .hs_sel   (hs_sel),
      .ch_valid (ch_valid),
      .ch_data  (ch_data),
      .cmd_valid(cmd_valid),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .slot_tag (slot_tag),
      .slot_word(slot_word)
   );

   aclink_frame_packer #(
      .SLOT_W   (SLOT_W),
      .NUM_SLOTS(NUM_SLOTS),
      .TAG_W    (TAG_W)
   ) u_packer (
      .slot_tag (slot_tag),
      .slot_word(slot_word),
      .frame    (frame)
   );

   aclink_frame_shifter #(
      .FRAME_BITS(FRAME_BITS),
      .TAG_W     (TAG_W)
   ) u_shifter (
      .clk        (bit_clk),
      .rst_n      (rst_n),
      .frame_in   (frame),
      .load_strobe(load_strobe),
      .sync       (sync),
      .sdata      (sdata)
   );

   assign ch_ready  = {NUM_CH{load_strobe}};
   assign cmd_ready = load_strobe;

   // R8
   route_exclusive_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !(slot_tag[5] && slot_tag[10]));

   // R11
   cmd_idle_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !cmd_valid |-> (!slot_tag[0] && !slot_tag[1]));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
      // R10
      untagged_zero_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
         !slot_tag[i] |-> (slot_word[i] == '0));
   end

endmodule

// File: tb/tb_aclink_out_framer.sv
module tb_aclink_out_framer;

   localparam int CLK_PERIOD = 10;

   logic         bit_clk = 1'b0;
   logic         rst_n   = 1'b0;
   logic         hs_sel  = 1'b0;
   logic [4:0]   ch_valid = '0;
   logic [159:0] ch_data  = '0;
   logic [4:0]   ch_ready;
   logic         cmd_valid = 1'b0;
   logic [19:0]  cmd_addr  = '0;
   logic [19:0]  cmd_data  = '0;
   logic         cmd_ready;
   logic         sync;
   logic         sdata;

   int n_checks = 0;
   int n_fail   = 0;
   logic [255:0] exp_q [$];

   always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

   aclink_out_framer dut (
      .bit_clk  (bit_clk),
      .rst_n    (rst_n),
      .hs_sel   (hs_sel),
      .ch_valid (ch_valid),
      .ch_data  (ch_data),
      .ch_ready (ch_ready),
      .cmd_valid(cmd_valid),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .cmd_ready(cmd_ready),
      .sync     (sync),
      .sdata    (sdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string slot_req(input int s);
      case (s)
         1, 2:   return "R11";
         3, 4:   return "R5";
         5, 9:   return "R6";
         7, 8:   return "R7";
         6, 11:  return "R8";
         default: return "R10";
      endcase
   endfunction

   // Expected frame built from the requirement text (R1, R4..R11)
   function automatic logic [255:0] exp_frame(input logic [4:0] v, input logic [159:0] d,
                                              input logic hs, input logic cv,
                                              input logic [19:0] ca, input logic [19:0] cd);
      logic [19:0]  w [1:12];
      logic [12:1]  t;
      logic [255:0] f;
      for (int s = 1; s <= 12; s++) w[s] = '0;
      t = '0;
      if (cv)   begin w[1] = ca; w[2] = cd; t[1] = 1; t[2] = 1; end
      if (v[0]) begin w[3] = {d[16 +: 16], 4'h0}; w[4] = {d[0 +: 16], 4'h0}; t[3] = 1; t[4] = 1; end
      if (v[1]) begin w[5] = {d[32 +: 16], 4'h0}; t[5] = 1; end
      if (v[2]) begin
         if (hs) begin w[11] = {d[64 +: 16], 4'h0}; t[11] = 1; end
         else    begin w[6]  = {d[64 +: 16], 4'h0}; t[6]  = 1; end
      end
      if (v[3]) begin w[7] = {d[112 +: 16], 4'h0}; w[8] = {d[96 +: 16], 4'h0}; t[7] = 1; t[8] = 1; end
      if (v[4]) begin w[9] = {d[128 +: 16], 4'h0}; t[9] = 1; end
      f = '0;
      f[255] = |t;
      for (int s = 1; s <= 12; s++) begin
         f[255 - s] = t[s];
         f[(12 - s)*20 +: 20] = w[s];
      end
      return f;
   endfunction

   // Driver: present one frame's worth of inputs at the capture cycle
   task automatic drive_frame(input logic [4:0] v, input logic [159:0] d, input logic hs,
                              input logic cv, input logic [19:0] ca, input logic [19:0] cd);
      @(negedge bit_clk);
      while (!cmd_ready) @(negedge bit_clk);
      ch_valid = v; ch_data = d; hs_sel = hs;
      cmd_valid = cv; cmd_addr = ca; cmd_data = cd;
      exp_q.push_back(exp_frame(v, d, hs, cv, ca, cd));
      @(negedge bit_clk);
      // R3: changes outside the capture cycle must not reach the frame
      ch_valid = 5'h1F; ch_data = ~d; hs_sel = ~hs;
      cmd_valid = 1'b1; cmd_addr = ~ca; cmd_data = ~cd;
      repeat (3) @(negedge bit_clk);
      ch_valid = '0; cmd_valid = 1'b0;
   endtask

   // Monitor: collect each frame from the wire and compare with the queue
   logic [255:0] act_f;
   int  idx = 0;
   bit  started = 0;
   bit  prev_sync = 0;
   int  sync_err = 0;
   int  rdy_err = 0;

   task automatic compare_frame();
      logic [255:0] ef;
      logic [19:0]  aw, ew;
      if (exp_q.size() == 0) return;
      ef = exp_q.pop_front();
      check(act_f[255:240] == ef[255:240], "R4", {16'h0, act_f[255:240]}, {16'h0, ef[255:240]});
      for (int s = 1; s <= 12; s++) begin
         aw = act_f[(12 - s)*20 +: 20];
         ew = ef[(12 - s)*20 +: 20];
         if (s <= 2) begin
            check(aw == ew, slot_req(s), {12'h0, aw}, {12'h0, ew});
         end else begin
            check(aw[19:4] == ew[19:4], slot_req(s), {12'h0, aw}, {12'h0, ew});
            check(aw[3:0] == 4'h0, "R9", {28'h0, aw[3:0]}, 32'h0);
         end
      end
      check(sync_err == 0, "R2", sync_err, 0);
      check(rdy_err == 0, "R3", rdy_err, 0);
   endtask

   initial begin
      forever begin
         @(negedge bit_clk);
         if (rst_n) begin
            if (sync && !prev_sync) begin
               if (started) check(idx == 256, "R1", idx, 256);
               started  = 1;
               idx      = 0;
               sync_err = 0;
               rdy_err  = 0;
            end
            if (started && idx < 256) begin
               act_f[255 - idx] = sdata;
               if (sync != (idx < 16)) sync_err++;
               if ((ch_ready != {5{idx == 255}}) || (cmd_ready != (idx == 255))) rdy_err++;
               idx++;
               if (idx == 256) compare_frame();
            end
            prev_sync = sync;
         end
      end
   end

   // Watchdog
   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [159:0] d;
      // R12: reset state, and first frame all zero
      exp_q.push_back('0);
      repeat (3) @(negedge bit_clk);
      check(sync == 1'b1, "R12", sync, 1);
      check(sdata == 1'b0, "R12", sdata, 0);
      check(ch_ready == 5'h0, "R12", ch_ready, 0);
      repeat (2) @(posedge bit_clk);
      #2 rst_n = 1'b1;

      d = {32'h1357_9BDF, 32'h2468_ACE0, 32'hCAFE_F00D, 32'h0F0F_F0F0, 32'hA5A5_5A5A};
      drive_frame(5'h1F, d, 1'b0, 1'b0, 20'h0, 20'h0);        // all lanes, center in slot 6 (R8)
      d = {32'h8000_0001, 32'h7FFF_8000, 32'hBEEF_1234, 32'h0001_FFFF, 32'hFFFF_0001};
      drive_frame(5'h1F, d, 1'b1, 1'b0, 20'h0, 20'h0);        // headset in slot 11 (R8, R9)
      drive_frame(5'h00, ~d, 1'b0, 1'b0, 20'h0, 20'h0);       // nothing valid (R10)
      d = {32'h0000_4321, 32'h5555_AAAA, 32'h0000_9876, 32'h1111_C3C3, 32'h2222_3333};
      drive_frame(5'h12, d, 1'b0, 1'b1, 20'h8_0026, 20'h0_1F40); // modem, LFE, command (R6, R11)
      drive_frame(5'h01, d, 1'b1, 1'b0, 20'h0, 20'h0);        // main stereo only (R5)
      drive_frame(5'h00, d, 1'b0, 1'b1, 20'hF_FFFF, 20'hA_5A5A); // command only (R11, R4)
      drive_frame(5'h04, d, 1'b1, 1'b0, 20'h0, 20'h0);        // headset only (R8)
      drive_frame(5'h08, d, 1'b0, 1'b0, 20'h0, 20'h0);        // surround only (R7)
      drive_frame(5'h04, d, 1'b0, 1'b0, 20'h0, 20'h0);        // center only (R8)

      while (exp_q.size() != 0) @(negedge bit_clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule